// File: doc/BRIEF.md
# Idle Power-Down and Wake Controller

This block parks a processor pipeline in a low-power idle state when software writes to ancillary state register 19, and brings it back out when an interrupt becomes pending. A request is accepted only when the written value is zero and the core is in supervisor mode with traps enabled. A request that breaks any of these rules does not enter idle. It sets a sticky error flag instead, and the core keeps running. While idle, the pipeline is halted. A configuration input chooses whether the core and FPU clock enable is also dropped.

On wake, the controller first restores the clock enable for one cycle while the halt is still held, so the pipeline restarts on a clean edge. It then releases the halt and enters a resume window. In that window the interrupt trap is held back until the instruction after the power-down write has retired. A fetch counter lets at most six sequential fetches through. After that, further fetches stall until the pipeline reports that the trap has been taken.

The states are RUN, IDLE, WAKE and RESUME. The transitions are:
- RUN→IDLE on a legal request.
- IDLE→WAKE when an interrupt is pending.
- WAKE→RESUME unconditionally.
- RESUME→RUN when a trap is taken while trap-allow is high.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset the controller is in RUN, with pipe_halt=0, core_clk_en=1, trap_allow=1, fetch_stall=0 and req_err=0.
- R2: A write with asr_wr_num=19, asr_wr_data=0, sv_mode=1 and traps_en=1 sets pipe_halt=1 from the cycle after the write strobe.
- R3: A write to register 19 with non-zero data, with sv_mode=0, or with traps_en=0 leaves pipe_halt=0 and sets req_err=1 from the next cycle.
- R4: req_err stays 1 until reset, even after later legal requests. A write to any register number other than 19 changes neither pipe_halt nor req_err.
- R5: In IDLE, pipe_halt=1 and trap_allow=0, and the controller stays idle for as long as irq_pending=0.
- R6: In IDLE, core_clk_en=0 when gate_en=1 and core_clk_en=1 when gate_en=0. Outside IDLE, core_clk_en=1.
- R7: When irq_pending=1 in IDLE, the next cycle (WAKE) has core_clk_en=1 and pipe_halt=1, and the cycle after that has pipe_halt=0.
- R8: In RESUME, trap_allow=0 until a retire pulse. trap_allow=1 from the cycle after the first retire.
- R9: In RESUME, each cycle with fetch_req=1 and fetch_stall=0 counts one fetch. Once six fetches have counted, fetch_stall=1 until the controller leaves RESUME.
- R10: trap_taken=1 in RESUME while trap_allow=1 returns the controller to RUN on the next cycle, with fetch_stall=0 and trap_allow=1. trap_taken while trap_allow=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asr_wr_en | input | 1 | Ancillary state register write strobe |
| asr_wr_num | input | 5 | Register number of the write |
| asr_wr_data | input | 32 | Data of the write |
| sv_mode | input | 1 | Core is in supervisor mode |
| traps_en | input | 1 | Trap enable status bit |
| irq_pending | input | 1 | An interrupt is pending |
| gate_en | input | 1 | 1: drop the clock enable while idle |
| retire | input | 1 | Pulse when an instruction retires |
| fetch_req | input | 1 | Pipeline requests a sequential fetch |
| trap_taken | input | 1 | Pipeline has taken the interrupt trap |
| pipe_halt | output | 1 | Pipeline halt |
| core_clk_en | output | 1 | Core and FPU clock enable |
| trap_allow | output | 1 | Interrupt trap may be taken |
| fetch_stall | output | 1 | Sequential fetch must wait |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
Every output is decoded from registered state, so a stimulus applied before a rising edge shows at the outputs one cycle later. This holds for the entry into IDLE, the error flag, WAKE, the trap-allow rise after a retire, and the return to RUN. RESUME follows WAKE after exactly one more cycle. The stall appears in the cycle after the sixth accepted fetch. The bench drives inputs on the falling edge, steps through exactly one rising edge, and samples at the next falling edge, so each check lands in the cycle the requirement names.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_WAKE   = 2'd2,
        ST_RESUME = 2'd3
    } idle_state_t;

endpackage

// File: rtl/idle_req_check.sv
module idle_req_check #(
    parameter int NUM_W   = 5,
    parameter int DATA_W  = 32,
    parameter int ASR_IDX = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_W-1:0]  wr_num,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sv_mode,
    input  logic              traps_en,
    output logic              req_ok,
    output logic              req_bad,
    output logic              err_flag
);

    logic hit;
    logic data_zero;

    always_comb begin
        hit       = wr_en && (wr_num == NUM_W'(ASR_IDX));
        data_zero = (wr_data == '0);
        req_ok    = hit && data_zero && sv_mode && traps_en;
        req_bad   = hit && !req_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (req_bad) begin
            err_flag <= 1'b1;
        end
    end

    // R3: an illegal request shows in the flag on the next cycle
    a_r3_bad_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        req_bad |=> err_flag);

    // R4: the flag never clears without reset
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

// File: rtl/idle_fetch_limit.sv
module idle_fetch_limit #(
    parameter int FETCH_MAX = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_resume,
    input  logic fetch_req,
    output logic fetch_stall
);

    localparam int CNT_W = $clog2(FETCH_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic             at_cap;

    always_comb begin
        at_cap      = (cnt == CNT_W'(FETCH_MAX));
        fetch_stall = in_resume && at_cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!in_resume) begin
            cnt <= '0;
        end else if (fetch_req && !at_cap) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: the counter never passes the cap
    a_r9_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FETCH_MAX));

    // R9: once stalled inside the window, stay stalled while the window lasts
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && in_resume) |=> (fetch_stall || !in_resume));

endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
    import idle_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_ok,
    input  logic        req_bad,
    input  logic        irq_pending,
    input  logic        gate_en,
    input  logic        retire,
    input  logic        trap_taken,
    output idle_state_t state,
    output logic        pipe_halt,
    output logic        core_clk_en,
    output logic        trap_allow
);

    idle_state_t state_nx;
    logic        retired;

    // state register and retire tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_RUN;
            retired <= 1'b0;
        end else begin
            state <= state_nx;
            if (state != ST_RESUME) begin
                retired <= 1'b0;
            end else if (retire) begin
                retired <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (req_ok) state_nx = ST_IDLE;
            ST_IDLE:   if (irq_pending) state_nx = ST_WAKE;
            ST_WAKE:   state_nx = ST_RESUME;
            ST_RESUME: if (trap_taken && trap_allow) state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        pipe_halt   = 1'b0;
        core_clk_en = 1'b1;
        trap_allow  = 1'b1;
        unique case (state)
            ST_RUN: begin
                pipe_halt  = 1'b0;
                trap_allow = 1'b1;
            end
            ST_IDLE: begin
                pipe_halt   = 1'b1;
                core_clk_en = !gate_en;
                trap_allow  = 1'b0;
            end
            ST_WAKE: begin
                pipe_halt   = 1'b1;
                core_clk_en = 1'b1;
                trap_allow  = 1'b0;
            end
            ST_RESUME: begin
                pipe_halt  = 1'b0;
                trap_allow = retired;
            end
            default: begin
                pipe_halt = 1'b0;
            end
        endcase
    end

    // R3: an illegal request never leads into idle
    a_r3_bad_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && req_bad) |=> (state != ST_IDLE));

    // R5: halt held while idle
    a_r5_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (pipe_halt && !trap_allow));

    // R7: clock enable comes back before the halt is released
    a_r7_clk_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pipe_halt) |-> $past(core_clk_en));

    // R8: trap-allow rises inside the window only after a retire
    a_r8_retire_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trap_allow) && state == ST_RESUME) |-> $past(retire));

    // R10: a trap that is taken while allowed ends the window
    a_r10_trap_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESUME && trap_allow && trap_taken) |=> (state == ST_RUN));

endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
    import idle_pkg::*;
#(
    parameter int NUM_W     = 5,
    parameter int DATA_W    = 32,
    parameter int ASR_IDX   = 19,
    parameter int FETCH_MAX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              asr_wr_en,
    input  logic [NUM_W-1:0]  asr_wr_num,
    input  logic [DATA_W-1:0] asr_wr_data,
    input  logic              sv_mode,
    input  logic              traps_en,
    input  logic              irq_pending,
    input  logic              gate_en,
    input  logic              retire,
    input  logic              fetch_req,
    input  logic              trap_taken,
    output logic              pipe_halt,
    output logic              core_clk_en,
    output logic              trap_allow,
    output logic              fetch_stall,
    output logic              req_err
);

    logic        req_ok;
    logic        req_bad;
    logic        in_resume;
    idle_state_t state;

    idle_req_check #(
        .NUM_W   (NUM_W),
        .DATA_W  (DATA_W),
        .ASR_IDX (ASR_IDX)
    ) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (asr_wr_en),
        .wr_num   (asr_wr_num),
        .wr_data  (asr_wr_data),
        .sv_mode  (sv_mode),
        .traps_en (traps_en),
        .req_ok   (req_ok),
        .req_bad  (req_bad),
        .err_flag (req_err)
    );

    idle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_ok      (req_ok),
        .req_bad     (req_bad),
        .irq_pending (irq_pending),
        .gate_en     (gate_en),
        .retire      (retire),
        .trap_taken  (trap_taken),
        .state       (state),
        .pipe_halt   (pipe_halt),
        .core_clk_en (core_clk_en),
        .trap_allow  (trap_allow)
    );

    assign in_resume = (state == ST_RESUME);

    idle_fetch_limit #(
        .FETCH_MAX (FETCH_MAX)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_resume   (in_resume),
        .fetch_req   (fetch_req),
        .fetch_stall (fetch_stall)
    );

    // R6: clock enable only drops while the pipeline is halted
    a_r6_gate_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> pipe_halt);

endmodule

// File: tb/test_idle_pwr_ctrl.sv
module test_idle_pwr_ctrl;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        asr_wr_en;
    logic [4:0]  asr_wr_num;
    logic [31:0] asr_wr_data;
    logic        sv_mode, traps_en, irq_pending, gate_en;
    logic        retire, fetch_req, trap_taken;
    logic        pipe_halt, core_clk_en, trap_allow, fetch_stall, req_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    idle_pwr_ctrl i_idle_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .asr_wr_en(asr_wr_en), .asr_wr_num(asr_wr_num),
        .asr_wr_data(asr_wr_data), .sv_mode(sv_mode), .traps_en(traps_en),
        .irq_pending(irq_pending), .gate_en(gate_en), .retire(retire),
        .fetch_req(fetch_req), .trap_taken(trap_taken), .pipe_halt(pipe_halt),
        .core_clk_en(core_clk_en), .trap_allow(trap_allow),
        .fetch_stall(fetch_stall), .req_err(req_err)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        asr_wr_en = 0; asr_wr_num = 0; asr_wr_data = 0;
        sv_mode = 1; traps_en = 1; irq_pending = 0; gate_en = 1;
        retire = 0; fetch_req = 0; trap_taken = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic write_asr(input logic [4:0] num, input logic [31:0] data);
        asr_wr_en = 1; asr_wr_num = num; asr_wr_data = data;
        step();
        asr_wr_en = 0; asr_wr_num = 0; asr_wr_data = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "pipe_halt", pipe_halt, 0);
        chk("R1", "core_clk_en", core_clk_en, 1);
        chk("R1", "trap_allow", trap_allow, 1);
        chk("R1", "fetch_stall", fetch_stall, 0);
        chk("R1", "req_err", req_err, 0);
    endtask

    task automatic t_bad_requests();
        do_reset();
        write_asr(5'd18, 32'h0);
        chk("R4", "other reg halt", pipe_halt, 0);
        chk("R4", "other reg err", req_err, 0);
        write_asr(5'd19, 32'h0000_0010);
        chk("R3", "nonzero data halt", pipe_halt, 0);
        chk("R3", "nonzero data err", req_err, 1);
        do_reset();
        sv_mode = 0;
        write_asr(5'd19, 32'h0);
        chk("R3", "user mode halt", pipe_halt, 0);
        chk("R3", "user mode err", req_err, 1);
        do_reset();
        traps_en = 0;
        write_asr(5'd19, 32'h0);
        chk("R3", "traps off halt", pipe_halt, 0);
        chk("R3", "traps off err", req_err, 1);
        traps_en = 1;
        step();
        chk("R4", "err sticky", req_err, 1);
    endtask

    task automatic t_idle_gated();
        do_reset();
        gate_en = 1;
        write_asr(5'd19, 32'h0);
        chk("R2", "halt after legal write", pipe_halt, 1);
        chk("R5", "trap blocked idle", trap_allow, 0);
        chk("R6", "clk gated", core_clk_en, 0);
        for (int i = 0; i < 5; i++) step();
        chk("R5", "still idle", pipe_halt, 1);
        trap_taken = 1;
        step();
        trap_taken = 0;
        chk("R5", "still idle after stray trap", pipe_halt, 1);
        irq_pending = 1;
        step();
        irq_pending = 0;
        chk("R7", "wake clk_en", core_clk_en, 1);
        chk("R7", "wake halt", pipe_halt, 1);
        step();
        chk("R7", "resume halt released", pipe_halt, 0);
        chk("R8", "trap held before retire", trap_allow, 0);
        trap_taken = 1;
        step();
        trap_taken = 0;
        chk("R10", "trap ignored without allow", trap_allow, 0);
        chk("R10", "still resume", pipe_halt, 0);
        retire = 1;
        step();
        retire = 0;
        chk("R8", "trap allowed after retire", trap_allow, 1);
        trap_taken = 1;
        step();
        trap_taken = 0;
        chk("R10", "run trap_allow", trap_allow, 1);
        chk("R10", "run no stall", fetch_stall, 0);
        chk("R4", "no err on legal", req_err, 0);
    endtask

    task automatic t_fetch_cap();
        do_reset();
        write_asr(5'd19, 32'h0);
        irq_pending = 1;
        step();
        irq_pending = 0;
        step();
        fetch_req = 1;
        for (int i = 1; i <= 6; i++) begin
            chk("R9", "no stall before cap", fetch_stall, 0);
            step();
        end
        chk("R9", "stall at six", fetch_stall, 1);
        step(); step();
        chk("R9", "stall held", fetch_stall, 1);
        fetch_req = 0;
        retire = 1;
        step();
        retire = 0;
        chk("R9", "stall held after retire", fetch_stall, 1);
        trap_taken = 1;
        step();
        trap_taken = 0;
        chk("R10", "stall cleared in run", fetch_stall, 0);
    endtask

    task automatic t_no_gate();
        do_reset();
        gate_en = 0;
        write_asr(5'd19, 32'h0);
        chk("R6", "ungated idle halt", pipe_halt, 1);
        chk("R6", "ungated clk_en", core_clk_en, 1);
        irq_pending = 1;
        step();
        irq_pending = 0;
        step();
        chk("R7", "ungated resume", pipe_halt, 0);
    endtask

    task automatic t_err_then_legal();
        do_reset();
        write_asr(5'd19, 32'h1);
        write_asr(5'd19, 32'h0);
        chk("R4", "legal after err enters idle", pipe_halt, 1);
        chk("R4", "err still set", req_err, 1);
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        t_reset();
        t_bad_requests();
        t_idle_gated();
        t_fetch_cap();
        t_no_gate();
        t_err_then_legal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule